// File: doc/BRIEF.md
# Real-time counter with alarms

This peripheral keeps time as a 32-bit count of ticks. A prescaler counts strobes of a slow reference clock, one strobe per slow-clock period, delivered on `slow_pulse` in the system clock domain. It emits one tick for every 2*(DIV+1) strobes. With a 32768 Hz reference and DIV = 1023 the count therefore advances at 16 Hz, and bits [3:0] of the count hold sixteenths of a second. Counting runs only while the clock-select register holds the code 3.

Two compare alarms watch the count. Each raises its own event flag when the count steps onto its value, but only while that alarm is enabled. Every tick also raises a periodic event flag. The event flags share one status register with their enables. The events are cleared by writing 1 to them. A level interrupt reports any event whose enable is set. A 32-bit scratch register lets software keep one word of its own, such as an epoch extension.

The host uses a plain single-cycle port. A write takes effect at the clock edge where `host_wr` is high. A read is combinational: `host_rdata` shows the register at `host_addr` during the same cycle. There is no back-pressure, and the host may issue an access in any cycle.

Top module: `rtc_timer`

## Requirements
- R1: After reset every register reads 0: counter 0x00, alarm0 0x04, status 0x08, divider 0x0C, alarm1 0x18, clock select 0x1C and scratch 0x40. `irq` is low after reset, and unmapped addresses read 0.
- R2: While the clock select is 3, a tick occurs on every 2*(DIV+1)-th `slow_pulse` strobe. Each tick adds 1 to the counter read at 0x00.
- R3: While clock select bits [1:0] hold any code other than 3, strobes are ignored, and the counter and the prescaler hold their values.
- R4: A host write to 0x00 loads the written count. If a tick falls in the same cycle, the written value is kept.
- R5: A tick at count 0xFFFFFFFF gives count 0.
- R6: Status bit 0 (alarm0 event) sets when status bit 2 (alarm0 enable) is 1 and a tick advances the counter to the alarm0 value. Status bit 4 and enable bit 6 behave the same way for alarm1. A disabled alarm, or a host load of the matching value, sets nothing.
- R7: Writing status with 1 in an event bit (0, 1 or 4) clears that bit, and writing 0 leaves it unchanged. The enable bits 2, 3 and 6 take the written value. An event arriving in the same cycle as its clear leaves the bit set.
- R8: Status bit 1 (tick event) sets on every tick. Bit 3 is its enable.
- R9: `irq` is high exactly when some event bit is set together with its enable bit.
- R10: The scratch register at 0x40 reads back the last value written, whatever the alarms do.
- R11: A write to the divider at 0x0C restarts the prescaler from zero. The next tick then needs a full 2*(DIV+1) strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slow_pulse | input | 1 | One-cycle strobe per slow reference period |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 8 | Byte address of the register |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data of the addressed register, same cycle |
| irq | output | 1 | Level interrupt |

## Verification
The prescaler is driven with back-to-back strobes and with gapped strobes at two divider values. This separates counting per strobe from counting per cycle, and shows whether the limit really is 2*(DIV+1). Strobes are also sent while the clock select holds another code, and just after a divider rewrite, to show the prescaler state is held and then restarted. Alarms are armed both enabled and disabled, with the count passing each value. Status writes mix 1s and 0s so that clearing, holding and the event-beats-clear collision each show a different readout. A count load lands in a tick cycle, and a load near all-ones covers the wrap.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NUM_ALARM = 2;

  localparam logic [7:0] A_COUNT   = 8'h00;
  localparam logic [7:0] A_ALARM0  = 8'h04;
  localparam logic [7:0] A_STATUS  = 8'h08;
  localparam logic [7:0] A_DIVIDER = 8'h0C;
  localparam logic [7:0] A_ALARM1  = 8'h18;
  localparam logic [7:0] A_CLKSEL  = 8'h1C;
  localparam logic [7:0] A_SCRATCH = 8'h40;

  localparam logic [1:0] CLK_RUN   = 2'b11;

  localparam int B_TICK_EV = 1;
  localparam int B_TICK_EN = 3;

  function automatic int alarm_ev_bit(input int idx);
    return 4 * idx;
  endfunction

  function automatic int alarm_en_bit(input int idx);
    return 4 * idx + 2;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             slow_pulse,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int PC_W = DIV_W + 1;

  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] limit;

  assign limit = {div, 1'b1};
  assign tick  = run && slow_pulse && !restart && (pc == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
    end else if (restart) begin
      pc <= '0;
    end else if (run && slow_pulse) begin
      pc <= tick ? '0 : pc + 1'b1;
    end
  end

  p_pc_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pc <= limit);
  p_idle_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(pc));
  p_tick_needs_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> slow_pulse);
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (tick) cnt <= cnt + 1'b1;
  end

  p_load_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == $past(load_val));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cnt));
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && (&cnt)) |=> cnt == '0);
endmodule

// File: rtl/rtc_events.sv
module rtc_events
  import rtc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick,
  input  logic                          cnt_load,
  input  logic [W-1:0]                  cnt,
  input  logic [NUM_ALARM-1:0][W-1:0]   alarm,
  input  logic                          st_wr,
  input  logic [7:0]                    st_wdata,
  output logic [7:0]                    status,
  output logic                          irq
);
  logic [W-1:0]         nxt;
  logic [NUM_ALARM-1:0] hit, ev_al, en_al;
  logic                 ev_tick, en_tick;

  assign nxt = cnt + 1'b1;

  for (genvar i = 0; i < NUM_ALARM; i++) begin : g_alarm
    localparam int EVB = alarm_ev_bit(i);
    localparam int ENB = alarm_en_bit(i);
    assign hit[i] = tick && !cnt_load && (nxt == alarm[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ev_al[i] <= 1'b0;
        en_al[i] <= 1'b0;
      end else begin
        if (hit[i] && en_al[i])         ev_al[i] <= 1'b1;
        else if (st_wr && st_wdata[EVB]) ev_al[i] <= 1'b0;
        if (st_wr) en_al[i] <= st_wdata[ENB];
      end
    end

    p_alarm_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ev_al[i]) |-> $past(en_al[i]));
    p_alarm_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr && st_wdata[EVB] && !hit[i]) |=> !ev_al[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_tick <= 1'b0;
      en_tick <= 1'b0;
    end else begin
      if (tick)                              ev_tick <= 1'b1;
      else if (st_wr && st_wdata[B_TICK_EV]) ev_tick <= 1'b0;
      if (st_wr) en_tick <= st_wdata[B_TICK_EN];
    end
  end

  always_comb begin
    status            = '0;
    status[B_TICK_EV] = ev_tick;
    status[B_TICK_EN] = en_tick;
    for (int i = 0; i < NUM_ALARM; i++) begin
      status[alarm_ev_bit(i)] = ev_al[i];
      status[alarm_en_bit(i)] = en_al[i];
    end
  end

  assign irq = (ev_tick && en_tick) || (|(ev_al & en_al));

  p_tick_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ev_tick);
  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_tick && (en_al == '0)) |-> !irq);
endmodule

// File: rtl/rtc_timer.sv
module rtc_timer
  import rtc_pkg::*;
#(
  parameter int W      = 32,
  parameter int DIV_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_pulse,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [W-1:0]      host_wdata,
  output logic [W-1:0]      host_rdata,
  output logic              irq
);
  logic [W-1:0]                  cnt, scratch;
  logic [NUM_ALARM-1:0][W-1:0]   alarm;
  logic [DIV_W-1:0]              div;
  logic [1:0]                    clksel;
  logic [7:0]                    status;
  logic                          tick, run;
  logic                          wr_cnt, wr_st, wr_div, wr_sel, wr_scr;
  logic [NUM_ALARM-1:0]          wr_al;

  assign wr_cnt   = host_wr && (host_addr == ADDR_W'(A_COUNT));
  assign wr_st    = host_wr && (host_addr == ADDR_W'(A_STATUS));
  assign wr_div   = host_wr && (host_addr == ADDR_W'(A_DIVIDER));
  assign wr_sel   = host_wr && (host_addr == ADDR_W'(A_CLKSEL));
  assign wr_scr   = host_wr && (host_addr == ADDR_W'(A_SCRATCH));
  assign wr_al[0] = host_wr && (host_addr == ADDR_W'(A_ALARM0));
  assign wr_al[1] = host_wr && (host_addr == ADDR_W'(A_ALARM1));
  assign run      = (clksel == CLK_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div     <= '0;
      clksel  <= '0;
      scratch <= '0;
      alarm   <= '0;
    end else begin
      if (wr_div) div     <= host_wdata[DIV_W-1:0];
      if (wr_sel) clksel  <= host_wdata[1:0];
      if (wr_scr) scratch <= host_wdata;
      for (int i = 0; i < NUM_ALARM; i++)
        if (wr_al[i]) alarm[i] <= host_wdata;
    end
  end

  rtc_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .slow_pulse(slow_pulse),
    .restart(wr_div), .div(div), .tick(tick)
  );

  rtc_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(wr_cnt),
    .load_val(host_wdata), .cnt(cnt)
  );

  rtc_events #(.W(W)) u_ev (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_load(wr_cnt), .cnt(cnt),
    .alarm(alarm), .st_wr(wr_st), .st_wdata(host_wdata[7:0]),
    .status(status), .irq(irq)
  );

  always_comb begin
    case (host_addr)
      ADDR_W'(A_COUNT):   host_rdata = cnt;
      ADDR_W'(A_ALARM0):  host_rdata = alarm[0];
      ADDR_W'(A_STATUS):  host_rdata = W'(status);
      ADDR_W'(A_DIVIDER): host_rdata = W'(div);
      ADDR_W'(A_ALARM1):  host_rdata = alarm[1];
      ADDR_W'(A_CLKSEL):  host_rdata = W'(clksel);
      ADDR_W'(A_SCRATCH): host_rdata = scratch;
      default:            host_rdata = '0;
    endcase
  end

  p_scratch_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_scr |=> $stable(scratch));
  p_sel_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt) |=> $stable(cnt));
endmodule

// File: tb/sim_rtc_timer.sv
module sim_rtc_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_pulse = 1'b0;
  logic        host_wr = 1'b0;
  logic [7:0]  host_addr = 8'h00;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        irq;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  rtc_timer u0 (
    .clk(clk), .rst_n(rst_n), .slow_pulse(slow_pulse), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq(irq)
  );

  // behavioural reference model
  logic [31:0] m_cnt, m_al0, m_al1, m_scr, m_div;
  logic [1:0]  m_sel;
  bit m_ev0, m_ev1, m_evt, m_en0, m_en1, m_ent;
  int m_pc;

  always @(posedge clk) begin
    bit tk, h0, h1, stw, cw, dw;
    logic [31:0] nx;
    if (!rst_n) begin
      m_cnt = 0; m_al0 = 0; m_al1 = 0; m_scr = 0; m_div = 0; m_sel = 0;
      m_ev0 = 0; m_ev1 = 0; m_evt = 0; m_en0 = 0; m_en1 = 0; m_ent = 0;
      m_pc = 0;
    end else begin
      dw  = host_wr && host_addr == 8'h0C;
      cw  = host_wr && host_addr == 8'h00;
      stw = host_wr && host_addr == 8'h08;
      tk  = (m_sel == 2'd3) && slow_pulse && !dw && (m_pc == 2 * int'(m_div) + 1);
      nx  = m_cnt + 32'd1;
      h0  = tk && !cw && nx == m_al0;
      h1  = tk && !cw && nx == m_al1;
      if (dw) m_pc = 0;
      else if (m_sel == 2'd3 && slow_pulse) m_pc = tk ? 0 : m_pc + 1;
      if (h0 && m_en0) m_ev0 = 1; else if (stw && host_wdata[0]) m_ev0 = 0;
      if (h1 && m_en1) m_ev1 = 1; else if (stw && host_wdata[4]) m_ev1 = 0;
      if (tk) m_evt = 1; else if (stw && host_wdata[1]) m_evt = 0;
      if (stw) begin
        m_en0 = host_wdata[2]; m_ent = host_wdata[3]; m_en1 = host_wdata[6];
      end
      if (cw) m_cnt = host_wdata; else if (tk) m_cnt = nx;
      if (host_wr) begin
        case (host_addr)
          8'h04: m_al0 = host_wdata;
          8'h18: m_al1 = host_wdata;
          8'h0C: m_div = {16'h0, host_wdata[15:0]};
          8'h1C: m_sel = host_wdata[1:0];
          8'h40: m_scr = host_wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return m_cnt;
      8'h04: return m_al0;
      8'h08: return {25'h0, m_en1, 1'b0, m_ev1, m_ent, m_en0, m_evt, m_ev0};
      8'h0C: return m_div;
      8'h18: return m_al1;
      8'h1C: return {30'h0, m_sel};
      8'h40: return m_scr;
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit m_irq();
    return (m_ev0 && m_en0) || (m_ev1 && m_en1) || (m_evt && m_ent);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model, then drive the next inputs
  task automatic step(input bit wr, input logic [7:0] a, input logic [31:0] d, input bit sp);
    @(negedge clk);
    if (rst_n) begin
      chk("R9 irq vs model", {31'h0, irq}, {31'h0, m_irq()});
      chk("R2 R7 rdata vs model", host_rdata, m_read(host_addr));
    end
    host_wr = wr; host_addr = a; host_wdata = d; slow_pulse = sp;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(1'b1, a, d, 1'b0);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, 32'h0, 1'b1);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    step(1'b0, a, 32'h0, 1'b0);
    #1 v = host_rdata;
  endtask

  initial begin : watchdog
    #1000000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h00, v); chk("R1 counter", v, 32'h0);
    rd(8'h08, v); chk("R1 status", v, 32'h0);
    rd(8'h1C, v); chk("R1 clksel", v, 32'h0);
    rd(8'h40, v); chk("R1 scratch", v, 32'h0);
    rd(8'h20, v); chk("R1 unmapped", v, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    // R2 back-to-back strobes, div 0 -> tick every 2 strobes
    wr(8'h1C, 32'h3);
    pulses(4);
    rd(8'h00, v); chk("R2 div0 count", v, 32'd2);
    // R2 gapped strobes, div 1 -> tick every 4 strobes
    wr(8'h0C, 32'h1);
    for (int i = 0; i < 8; i++) begin
      pulses(1); step(1'b0, 8'h00, 32'h0, 1'b0);
    end
    rd(8'h00, v); chk("R2 div1 count", v, 32'd4);
    // R3 other clock code ignores strobes
    wr(8'h1C, 32'h2);
    pulses(6);
    rd(8'h00, v); chk("R3 halted count", v, 32'd4);
    wr(8'h1C, 32'h3);
    // R5 wrap
    wr(8'h0C, 32'h0);
    wr(8'h00, 32'hFFFF_FFFE);
    pulses(2);
    rd(8'h00, v); chk("R5 before wrap", v, 32'hFFFF_FFFF);
    pulses(2);
    rd(8'h00, v); chk("R5 wrap to zero", v, 32'h0);
    // R4 load in a tick cycle
    pulses(1);
    step(1'b1, 8'h00, 32'h100, 1'b1);
    rd(8'h00, v); chk("R4 load wins", v, 32'h100);
    // R6 alarm0 enabled, alarm1 disabled
    wr(8'h04, 32'h105);
    wr(8'h18, 32'h103);
    wr(8'h08, 32'h04);
    pulses(10);
    rd(8'h00, v); chk("R6 count at alarm", v, 32'h105);
    rd(8'h08, v); chk("R6 alarm0 set, alarm1 not", v, 32'h07);
    chk("R9 irq on alarm0", {31'h0, irq}, 32'h1);
    // R7 clear bit0, leave bit1 by writing 0
    wr(8'h08, 32'h05);
    rd(8'h08, v); chk("R7 w1c", v, 32'h06);
    chk("R9 irq low after clear", {31'h0, irq}, 32'h0);
    // R8 tick enable
    wr(8'h08, 32'h0C);
    rd(8'h08, v); chk("R8 tick flag held", v, 32'h0E);
    chk("R8 irq on tick enable", {31'h0, irq}, 32'h1);
    wr(8'h08, 32'h0E);
    rd(8'h08, v); chk("R7 tick flag cleared", v, 32'h0C);
    pulses(2);
    rd(8'h08, v); chk("R8 tick flag reset by tick", v, 32'h0E);
    // R6 alarm1 enabled
    wr(8'h18, 32'h108);
    wr(8'h08, 32'h4C);
    pulses(4);
    rd(8'h08, v); chk("R6 alarm1 set", v, 32'h5E);
    // R10 scratch
    wr(8'h40, 32'hDEAD_BEEF);
    pulses(2);
    rd(8'h40, v); chk("R10 scratch", v, 32'hDEAD_BEEF);
    rd(8'h00, v); chk("R2 count check", v, 32'h109);
    // R11 divider rewrite restarts prescaler
    wr(8'h0C, 32'h1);
    pulses(3);
    wr(8'h0C, 32'h1);
    pulses(3);
    rd(8'h00, v); chk("R11 restart no tick", v, 32'h109);
    // R7 event beats clear in the same cycle
    step(1'b1, 8'h08, 32'h4E, 1'b1);
    rd(8'h00, v); chk("R11 tick after full count", v, 32'h10A);
    rd(8'h08, v); chk("R7 set beats clear", v, 32'h5E);
    step(1'b0, 8'h00, 32'h0, 1'b0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule